// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a serial bit stream into parallel characters. An external bit-time enable paces it. In the default asynchronous mode that enable pulses sixteen times per bit. In synchronous mode it pulses once per bit and stands for the rising edge of a supplied bit clock.

A falling edge on the idle-high line starts a frame. The receiver then confirms the start bit with a run of samples, collects five to eight data bits least-significant bit first, and optionally checks a parity bit. Last it samples one stop bit. The finished character is placed in a holding register along with a parity-error flag and a framing-error flag, and a ready flag is raised. The consumer reads the character and pulses a read strobe, which clears the ready flag and both error flags.

The serial input passes through a two-stage synchronizer before any decision is made on it. Configuration inputs must stay stable while a frame is in progress.

Top module: `serial_rx`

## Requirements
- R1: While `rx_en` is low the receiver stays idle, ignores the serial line and never raises `rx_ready`.
- R2: In asynchronous mode a high-to-low transition on the synchronized line starts start-bit validation. The line is sampled on each of the next 8 ticks. If any of those samples is high, the frame is dropped and the receiver waits for a new falling edge.
- R3: In synchronous mode the start bit is sampled on the first tick after the falling edge. Every later bit is sampled on one tick each.
- R4: In asynchronous mode each data, parity and stop bit is sampled once, 16 ticks after the previous sample. This places the samples at the bit centres, since the last validation sample falls mid start bit.
- R5: Data bits arrive LSB first. `cfg_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R6: For characters shorter than 8 bits, the unused upper bits of `rx_data` are zero.
- R7: With `cfg_par_en` high, one parity bit follows the data. It is even parity when `cfg_par_odd` is 0 and odd parity when it is 1. A mismatch sets `err_parity` together with the character. With `cfg_par_en` low there is no parity bit and `err_parity` stays 0.
- R8: A low stop-bit sample sets `err_frame`, and the character is still delivered.
- R9: In the cycle after the stop-bit sample, `rx_data`, `err_parity` and `err_frame` are loaded and `rx_ready` goes high. After reset all outputs are 0.
- R10: A high `rd_stb` clears `rx_ready`, `err_parity` and `err_frame` on the next edge. A load in the same cycle takes precedence over the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| tick_en | input | 1 | Bit-time clock enable (16 per bit async, 1 per bit sync) |
| cfg_sync | input | 1 | 1 selects synchronous mode |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Serial input, idle high |
| rd_stb | input | 1 | Read strobe, clears ready and error flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character available |
| err_parity | output | 1 | Parity error of held character |
| err_frame | output | 1 | Framing error of held character |

## Verification
The embedded assertions check several rules on every cycle: the forced idle state when disabled, the return to search after a high validation sample, at most one bit strobe per cycle, and the loading of ready and framing flags in the cycle after the stop sample. They also check that the upper bits are zero and that the read strobe clears the flags. Other behaviour can only be shown by the bench's scenarios: the exact bit alignment at bit centres, LSB-first assembly, parity polarity, recovery after a rejected glitch, and the per-tick timing of synchronous mode. The bench drives whole frames and compares the delivered characters and flags with the values it expects.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int START_SAMPLES = TICKS_PER_BIT / 2,
  parameter int NBW           = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic           sync_mode,
  input  logic           rxd_s,
  input  logic [NBW-1:0] nbits,
  input  logic           par_en,
  output logic           frame_go,
  output logic           data_smp,
  output logic           par_smp,
  output logic           stop_smp
);
  localparam int CW = $clog2(TICKS_PER_BIT);

  srx_state_e     state_q, state_d;
  logic [CW-1:0]  tcnt_q, tcnt_d;
  logic [NBW-1:0] bcnt_q, bcnt_d;
  logic           line_q;
  logic           fall, bit_pt, start_pt;

  assign fall     = line_q & ~rxd_s;
  assign bit_pt   = tick & (sync_mode | (tcnt_q == CW'(TICKS_PER_BIT - 1)));
  assign start_pt = tick & (sync_mode | (tcnt_q == CW'(START_SAMPLES - 1)));

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    bcnt_d   = bcnt_q;
    frame_go = 1'b0;
    data_smp = 1'b0;
    par_smp  = 1'b0;
    stop_smp = 1'b0;
    if (!en) begin
      state_d = S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (fall) begin
            state_d  = S_START;
            tcnt_d   = '0;
            frame_go = 1'b1;
          end
        end
        S_START: begin
          if (tick) begin
            if (rxd_s) begin
              state_d = S_IDLE;
            end else if (start_pt) begin
              state_d = S_DATA;
              tcnt_d  = '0;
              bcnt_d  = '0;
            end else begin
              tcnt_d = tcnt_q + CW'(1);
            end
          end
        end
        S_DATA, S_PAR, S_STOP: begin
          if (tick) tcnt_d = bit_pt ? '0 : tcnt_q + CW'(1);
          if (bit_pt) begin
            if (state_q == S_DATA) begin
              data_smp = 1'b1;
              bcnt_d   = bcnt_q + NBW'(1);
              if (bcnt_q == nbits - NBW'(1)) state_d = par_en ? S_PAR : S_STOP;
            end else if (state_q == S_PAR) begin
              par_smp = 1'b1;
              state_d = S_STOP;
            end else begin
              stop_smp = 1'b1;
              state_d  = S_IDLE;
            end
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      line_q  <= rxd_s;
    end
  end

  // R1: a disabled receiver is idle on the following cycle
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == S_IDLE);

  // R2: a high validation sample abandons the frame
  p_reject_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == S_START && tick && rxd_s) |=> state_q == S_IDLE);

  // R4: at most one bit strobe per cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_smp, par_smp, stop_smp}));
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DATA_W = 8,
  parameter int NBW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic              data_smp,
  input  logic              par_smp,
  input  logic              stop_smp,
  input  logic              rxd_s,
  input  logic [NBW-1:0]    nbits,
  input  logic              par_odd,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              perr_q,
  output logic              ferr_q
);
  localparam logic [NBW-1:0] DW_N = NBW'(DATA_W);

  logic [DATA_W-1:0] shift_q, shift_d, data_d, aligned;
  logic              ppend_q, ppend_d;
  logic              ready_d, perr_d, ferr_d;

  assign aligned = shift_q >> (DW_N - nbits);

  always_comb begin
    shift_d = shift_q;
    ppend_d = ppend_q;
    if (frame_go) begin
      shift_d = '0;
      ppend_d = 1'b0;
    end else if (data_smp) begin
      shift_d = {rxd_s, shift_q[DATA_W-1:1]};
    end else if (par_smp) begin
      ppend_d = (^shift_q) ^ rxd_s ^ par_odd;
    end
  end

  always_comb begin
    data_d  = data_q;
    ready_d = ready_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    if (stop_smp) begin
      data_d  = aligned;
      ready_d = 1'b1;
      perr_d  = ppend_q;
      ferr_d  = ~rxd_s;
    end else if (rd_stb) begin
      ready_d = 1'b0;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      ppend_q <= 1'b0;
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      ppend_q <= ppend_d;
      data_q  <= data_d;
      ready_q <= ready_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  // R9: ready follows the stop sample by one cycle
  p_load_sets_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_smp |=> ready_q);

  // R8: framing flag reflects the stop sample
  p_frame_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_smp |=> ferr_q == !$past(rxd_s));

  // R6: bits above the character length are zero after a load
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_smp |=> (data_q >> $past(nbits)) == '0);

  // R10: read strobe without a load clears all flags
  p_clear_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !stop_smp) |=> (!ready_q && !perr_q && !ferr_q));
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_BITS      = 5,
  parameter int LEN_W         = 2,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tick_en,
  input  logic              cfg_sync,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rxd,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame
);
  localparam int NBW = $clog2(DATA_W + 1);

  logic           rxd_s;
  logic [NBW-1:0] nbits;
  logic           frame_go, data_smp, par_smp, stop_smp;

  assign nbits = NBW'(MIN_BITS) + NBW'(cfg_len);

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .d   (rxd),
    .q   (rxd_s)
  );

  srx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .START_SAMPLES(TICKS_PER_BIT / 2), .NBW(NBW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .tick     (tick_en),
    .sync_mode(cfg_sync),
    .rxd_s    (rxd_s),
    .nbits    (nbits),
    .par_en   (cfg_par_en),
    .frame_go (frame_go),
    .data_smp (data_smp),
    .par_smp  (par_smp),
    .stop_smp (stop_smp)
  );

  srx_hold #(.DATA_W(DATA_W), .NBW(NBW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_go(frame_go),
    .data_smp(data_smp),
    .par_smp (par_smp),
    .stop_smp(stop_smp),
    .rxd_s   (rxd_s),
    .nbits   (nbits),
    .par_odd (cfg_par_odd),
    .rd_stb  (rd_stb),
    .data_q  (rx_data),
    .ready_q (rx_ready),
    .perr_q  (err_parity),
    .ferr_q  (err_frame)
  );
endmodule

// File: tb/tb_serial_rx.sv
module tb_serial_rx;
  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       tick_en = 1'b0;
  logic       cfg_sync = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame;

  int   n_chk = 0;
  int   n_fail = 0;
  int   tdiv = 0;
  exp_t q[$];

  serial_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick_en(tick_en),
    .cfg_sync(cfg_sync), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .rxd(rxd), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame)
  );

  always #5 clk = ~clk;

  // bit-time enable: one pulse every 8 clocks, driven away from the edge
  always @(negedge clk) begin
    tdiv    <= (tdiv == 7) ? 0 : tdiv + 1;
    tick_en <= (tdiv == 7);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick_en) @(posedge clk);
    end
    @(negedge clk);
  endtask

  // driver: sends one frame; pushes the expected item when push is set
  task automatic send(input logic [7:0] b, input bit push, input bit bad_par, input bit bad_stop);
    int   bpt;
    int   nb;
    logic [7:0] m;
    exp_t e;
    bpt = cfg_sync ? 1 : 16;
    nb  = 5 + int'(cfg_len);
    m   = 8'hFF >> (8 - nb);
    e.d  = b & m;
    e.pe = cfg_par_en & bad_par;
    e.fe = bad_stop;
    if (push) q.push_back(e);
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(bpt);
    for (int i = 0; i < nb; i++) begin
      rxd = b[i];
      wait_ticks(bpt);
    end
    if (cfg_par_en) begin
      rxd = (^(b & m)) ^ cfg_par_odd ^ bad_par;
      wait_ticks(bpt);
    end
    rxd = ~bad_stop;
    wait_ticks(bpt);
    rxd = 1'b1;
    wait_ticks(4 * bpt);
  endtask

  // monitor: pops expected items as characters appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rx_ready && !rd_stb) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1/R2 unexpected character", int'(rx_data), 0);
        end else begin
          e = q.pop_front();
          chk(rx_data == e.d, "R5/R6 data", int'(rx_data), int'(e.d));
          chk(err_parity == e.pe, "R7 parity flag", int'(err_parity), int'(e.pe));
          chk(err_frame == e.fe, "R8 framing flag", int'(err_frame), int'(e.fe));
        end
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(!rx_ready && !err_parity && !err_frame, "R10 clear on read",
            int'({rx_ready, err_parity, err_frame}), 0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(rx_data == 8'h00 && !rx_ready && !err_parity && !err_frame, "R9 reset state",
        int'({rx_ready, err_parity, err_frame, rx_data}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rx_ready, "R9 reset ready", int'(rx_ready), 0);

    // R1: disabled receiver ignores a complete frame
    send(8'h96, 1'b0, 1'b0, 1'b0);
    chk(!rx_ready, "R1 disabled ignores line", int'(rx_ready), 0);
    rx_en = 1'b1;
    wait_ticks(4);

    // R4 R5: 8-bit async frames
    send(8'hA5, 1'b1, 1'b0, 1'b0);
    send(8'h3C, 1'b1, 1'b0, 1'b0);
    send(8'h01, 1'b1, 1'b0, 1'b0);

    // R2: short low glitch is rejected, following frame intact
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(40);
    chk(!rx_ready, "R2 glitch rejected", int'(rx_ready), 0);
    send(8'h5A, 1'b1, 1'b0, 1'b0);

    // R6: short characters
    cfg_len = 2'b00; send(8'hFF, 1'b1, 1'b0, 1'b0);
    cfg_len = 2'b01; send(8'hEA, 1'b1, 1'b0, 1'b0);
    cfg_len = 2'b10; send(8'h81, 1'b1, 1'b0, 1'b0);
    cfg_len = 2'b11;

    // R7: even and odd parity, good and bad
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0; send(8'h37, 1'b1, 1'b0, 1'b0);
    cfg_par_odd = 1'b0; send(8'h37, 1'b1, 1'b1, 1'b0);
    cfg_par_odd = 1'b1; send(8'hC8, 1'b1, 1'b0, 1'b0);
    cfg_par_odd = 1'b1; send(8'hC8, 1'b1, 1'b1, 1'b0);
    cfg_par_en = 1'b0;

    // R8: low stop bit, then recovery
    send(8'h77, 1'b1, 1'b0, 1'b1);
    send(8'h12, 1'b1, 1'b0, 1'b0);

    // R3: synchronous mode, one tick per bit
    cfg_sync = 1'b1;
    send(8'hC3, 1'b1, 1'b0, 1'b0);
    cfg_len = 2'b10; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    send(8'h55, 1'b1, 1'b0, 1'b0);
    send(8'h2B, 1'b1, 1'b1, 1'b0);
    cfg_len = 2'b11; cfg_par_en = 1'b0;
    send(8'h00, 1'b1, 1'b0, 1'b1);

    wait_ticks(20);
    chk(q.size() == 0, "R9 all characters delivered (R3)", q.size(), 0);
    finish_run();
  end
endmodule